// File: doc/BRIEF.md
# Two-Processor Doorbell Mailbox

This block lets two processors raise and acknowledge doorbells across a set of channels. Processor 0 and processor 1 each own a register window. A processor rings channel n by writing a one to the channel's "set" bit in its own window. This marks channel n occupied in its own status register. The peer detects the doorbell by reading the ringing processor's status register. It acknowledges by writing a one to the channel's "clear" bit in its own window, and that write empties the flag in the other window. Only the receiving side can clear a flag, and only the sending side can set it.

The block has two register ports, one per processor. Each port decodes the full address map, so either processor can read either window. The block has no data path and no back-pressure. Every access completes in one cycle, so the ports carry no valid/ready handshake. Each processor has two interrupts, each gated by its own enable bit. The receive interrupt reports that the peer has rung a channel. The transmit-free interrupt reports that at least one of its own channels is free to ring.

Top module: `mbx_doorbell`

## Requirements
- R1: A synchronous active-high reset empties every channel flag and clears every interrupt enable. While it holds, and afterwards until software acts, all status reads and all interrupts are 0.
- R2: Address 0x3F0 is a read-only configuration register. Bits 7:0 return the channel count parameter `NCHAN` and the upper bits read 0. Writes to it have no effect.
- R3: Window p sits at byte base 0x10*p (p = 0 or 1). A write of 1 to bit 16+n of the window's set/clear register (offset 0x8) sets bit n of the window's status register (offset 0xC). Bits written as 0 change nothing.
- R4: A write of 1 to bit n of window p's set/clear register empties bit n of the other window's status register. It leaves window p's own status unchanged.
- R5: Read data is registered. The addressed register's value appears on the port's read bus one clock after the address is presented. The set/clear register always reads 0.
- R6: Set and clear bits for channel indices at or above `NCHAN` are ignored, and status bits at those indices read 0.
- R7: If one port sets a flag in the same cycle that the other port clears it, the flag ends up set.
- R8: The receive interrupt of processor p is high exactly when bit 0 (receive enable) of window p's enable register (offset 0x4) is 1 and any flag in the other window is set.
- R9: The transmit-free interrupt of processor p is high exactly when bit 1 (transmit-free enable) of window p's enable register is 1 and any of window p's own channel flags is empty.
- R10: Unmapped addresses read 0, and writes to them change nothing. Unmapped means anything outside the two windows' offsets 0x4, 0x8 and 0xC, misaligned or above 0x1F, and not 0x3F0. Writes to a status register change nothing.
- R11: Both ports see the same map, so either processor can read either window. When both ports write the same enable register in one cycle, port 1's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 2 | Write strobe, bit q for port q |
| bus_addr | input | 2*AW | Byte address, slice q*AW +: AW for port q |
| bus_wdata | input | 64 | Write data, slice q*32 +: 32 for port q |
| bus_rdata | output | 64 | Registered read data, slice q*32 +: 32 for port q |
| irq_rx | output | 2 | Receive interrupt, bit p for processor p |
| irq_txfree | output | 2 | Transmit-free interrupt, bit p for processor p |

## Verification
The bench builds the block with `NCHAN` = 6 and `AW` = 12. A count of 6 leaves set and clear bits 6 to 15 unimplemented, so writes carrying those bits show that they are ignored. It also makes a full window (status 0x3F) reachable, which is the point where the transmit-free interrupt drops. The 12-bit address reaches the configuration register at 0x3F0 as well as unmapped addresses just above the windows.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int NPROC    = 2;
  localparam int DW       = 32;
  localparam int TX_SHIFT = 16;
  localparam int CFG_ADDR = 'h3F0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IEN,
    SEL_SC,
    SEL_STAT,
    SEL_CFG
  } mbx_sel_e;
endpackage

// File: rtl/mbx_decode.sv
`timescale 1ns/1ps
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int AW    = 12,
  parameter int NCHAN = 6
) (
  input  logic [AW-1:0]          addr,
  input  logic                   we,
  input  logic [DW-1:0]          wdata,
  output logic [2*NCHAN-1:0]     set_req,
  output logic [2*NCHAN-1:0]     clr_req,
  output logic [NPROC-1:0]       ien_we,
  output mbx_sel_e               sel,
  output logic                   win
);
  logic in_win;

  // window space: 0x00..0x1F, word aligned
  assign in_win = (addr[AW-1:5] == '0) && (addr[1:0] == 2'b00);
  assign win    = addr[4];

  always_comb begin
    sel = SEL_NONE;
    if (addr == AW'(CFG_ADDR)) begin
      sel = SEL_CFG;
    end else if (in_win) begin
      case (addr[3:2])
        2'd1:    sel = SEL_IEN;
        2'd2:    sel = SEL_SC;
        2'd3:    sel = SEL_STAT;
        default: sel = SEL_NONE;
      endcase
    end
  end

  for (genvar p = 0; p < NPROC; p++) begin : g_win
    logic hit_sc;
    assign hit_sc = we && (sel == SEL_SC) && (win == 1'(p));
    // ring: own window flags
    assign set_req[p*NCHAN +: NCHAN]     = hit_sc ? wdata[TX_SHIFT +: NCHAN] : '0;
    // acknowledge: peer window flags
    assign clr_req[(1-p)*NCHAN +: NCHAN] = hit_sc ? wdata[0 +: NCHAN] : '0;
    assign ien_we[p] = we && (sel == SEL_IEN) && (win == 1'(p));
  end
endmodule

// File: rtl/mbx_flags.sv
`timescale 1ns/1ps
module mbx_flags #(
  parameter int NCHAN = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*NCHAN-1:0]   set_in,
  input  logic [2*NCHAN-1:0]   clr_in,
  output logic [2*NCHAN-1:0]   occ
);
  // set applied after clear: set wins on collision
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= (occ & ~clr_in) | set_in;
  end
endmodule

// File: rtl/mbx_irq.sv
`timescale 1ns/1ps
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int NCHAN = 6
) (
  input  logic [2*NCHAN-1:0] occ,
  input  logic [NPROC-1:0]   en_rx,
  input  logic [NPROC-1:0]   en_tx,
  output logic [NPROC-1:0]   irq_rx,
  output logic [NPROC-1:0]   irq_txfree
);
  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    assign irq_rx[p]     = en_rx[p] & (|occ[(1-p)*NCHAN +: NCHAN]);
    assign irq_txfree[p] = en_tx[p] & ~(&occ[p*NCHAN +: NCHAN]);
  end
endmodule

// File: rtl/mbx_doorbell.sv
`timescale 1ns/1ps
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int AW    = 12,
  parameter int NCHAN = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            bus_we,
  input  logic [2*AW-1:0]       bus_addr,
  input  logic [63:0]           bus_wdata,
  output logic [63:0]           bus_rdata,
  output logic [1:0]            irq_rx,
  output logic [1:0]            irq_txfree
);
  localparam int NP = NPROC;
  localparam int FW = NP * NCHAN;

  logic [NP-1:0][FW-1:0] set_port;
  logic [NP-1:0][FW-1:0] clr_port;
  logic [NP-1:0][NP-1:0] ien_port;
  logic [NP-1:0]         win_port;
  mbx_sel_e              sel_port [NP];
  logic [FW-1:0]         set_all;
  logic [FW-1:0]         clr_all;
  logic [FW-1:0]         occ;
  logic [NP-1:0]         en_rx;
  logic [NP-1:0]         en_tx;
  logic [NP-1:0][DW-1:0] rd_q;

  for (genvar q = 0; q < NP; q++) begin : g_port
    mbx_decode #(.AW(AW), .NCHAN(NCHAN)) u_dec (
      .addr    (bus_addr[q*AW +: AW]),
      .we      (bus_we[q]),
      .wdata   (bus_wdata[q*DW +: DW]),
      .set_req (set_port[q]),
      .clr_req (clr_port[q]),
      .ien_we  (ien_port[q]),
      .sel     (sel_port[q]),
      .win     (win_port[q])
    );

    logic [NCHAN-1:0] stat_sel;
    assign stat_sel = win_port[q] ? occ[NCHAN +: NCHAN] : occ[0 +: NCHAN];

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_q[q] <= '0;
      end else begin
        case (sel_port[q])
          SEL_CFG:  rd_q[q] <= DW'(8'(NCHAN));
          SEL_STAT: rd_q[q] <= DW'(stat_sel);
          SEL_IEN:  rd_q[q] <= DW'({en_tx[win_port[q]], en_rx[win_port[q]]});
          default:  rd_q[q] <= '0;
        endcase
      end
    end
  end

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int q = 0; q < NP; q++) begin
      set_all = set_all | set_port[q];
      clr_all = clr_all | clr_port[q];
    end
  end

  // enable registers: higher port index written last, so it wins
  always_ff @(posedge clk) begin
    if (rst) begin
      en_rx <= '0;
      en_tx <= '0;
    end else begin
      for (int q = 0; q < NP; q++) begin
        for (int p = 0; p < NP; p++) begin
          if (ien_port[q][p]) begin
            en_rx[p] <= bus_wdata[q*DW];
            en_tx[p] <= bus_wdata[q*DW+1];
          end
        end
      end
    end
  end

  mbx_flags #(.NCHAN(NCHAN)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_in (set_all),
    .clr_in (clr_all),
    .occ    (occ)
  );

  mbx_irq #(.NCHAN(NCHAN)) u_irq (
    .occ        (occ),
    .en_rx      (en_rx),
    .en_tx      (en_tx),
    .irq_rx     (irq_rx),
    .irq_txfree (irq_txfree)
  );

  assign bus_rdata = rd_q;
endmodule

// File: rtl/mbx_doorbell_chk.sv
`timescale 1ns/1ps
module mbx_doorbell_chk #(
  parameter int NCHAN = 6
) (
  input logic               clk,
  input logic               rst,
  input logic [2*NCHAN-1:0] set_all,
  input logic [2*NCHAN-1:0] clr_all,
  input logic [2*NCHAN-1:0] occ,
  input logic [1:0]         en_rx,
  input logic [1:0]         en_tx,
  input logic [1:0]         irq_rx,
  input logic [1:0]         irq_txfree
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (occ == '0 && en_rx == '0 && en_tx == '0 && irq_rx == '0 && irq_txfree == '0));

  assert_set_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (set_all != '0) |=> ((occ & $past(set_all)) == $past(set_all)));

  assert_clear_lands_R4: assert property (@(posedge clk) disable iff (rst)
    ((clr_all & ~set_all) != '0) |=> ((occ & $past(clr_all & ~set_all)) == '0));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    ((set_all & clr_all) != '0) |=> ((occ & $past(set_all & clr_all)) == $past(set_all & clr_all)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (set_all == '0 && clr_all == '0) |=> $stable(occ));

  assert_rx0_peer_R8: assert property (@(posedge clk) disable iff (rst)
    irq_rx[0] |-> (en_rx[0] && occ[NCHAN +: NCHAN] != '0));

  assert_rx1_peer_R8: assert property (@(posedge clk) disable iff (rst)
    irq_rx[1] |-> (en_rx[1] && occ[0 +: NCHAN] != '0));

  assert_tx0_free_R9: assert property (@(posedge clk) disable iff (rst)
    irq_txfree[0] |-> (en_tx[0] && occ[0 +: NCHAN] != '1));

  assert_tx1_free_R9: assert property (@(posedge clk) disable iff (rst)
    irq_txfree[1] |-> (en_tx[1] && occ[NCHAN +: NCHAN] != '1));
endmodule

bind mbx_doorbell mbx_doorbell_chk #(.NCHAN(NCHAN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .set_all    (set_all),
  .clr_all    (clr_all),
  .occ        (occ),
  .en_rx      (en_rx),
  .en_tx      (en_tx),
  .irq_rx     (irq_rx),
  .irq_txfree (irq_txfree)
);

// File: tb/mbx_doorbell_test.sv
`timescale 1ns/1ps
module mbx_doorbell_test;
  localparam int AW    = 12;
  localparam int NCHAN = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      bus_we = '0;
  logic [2*AW-1:0] bus_addr = '0;
  logic [63:0]     bus_wdata = '0;
  logic [63:0]     bus_rdata;
  logic [1:0]      irq_rx;
  logic [1:0]      irq_txfree;

  int nchk  = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  mbx_doorbell #(.AW(AW), .NCHAN(NCHAN)) uut (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_rx     (irq_rx),
    .irq_txfree (irq_txfree)
  );

  typedef struct packed {
    logic        wq;
    logic        wen;
    logic [11:0] wa;
    logic [31:0] wd;
    logic        rq;
    logic [11:0] ra;
    logic [31:0] ex;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 12'h008, 32'h0001_0000, 1'b0, 12'h00C, 32'h01, 8'd3},  // R3 ring ch0 win0
    '{1'b0, 1'b1, 12'h008, 32'h0024_0000, 1'b0, 12'h00C, 32'h25, 8'd3},  // R3 ring ch2, ch5
    '{1'b1, 1'b1, 12'h018, 32'h0000_0004, 1'b1, 12'h00C, 32'h21, 8'd4},  // R4 p1 acks ch2, R11 p1 reads win0
    '{1'b1, 1'b1, 12'h018, 32'hFFC0_0000, 1'b1, 12'h01C, 32'h00, 8'd6},  // R6 out-of-range set bits
    '{1'b1, 1'b1, 12'h018, 32'h0003_0000, 1'b0, 12'h01C, 32'h03, 8'd3},  // R3 ring ch0, ch1 win1
    '{1'b0, 1'b1, 12'h008, 32'h0000_0001, 1'b1, 12'h01C, 32'h02, 8'd4},  // R4 p0 acks ch0 of win1
    '{1'b0, 1'b0, 12'h000, 32'h0000_0000, 1'b0, 12'h00C, 32'h21, 8'd4},  // R4 own window untouched
    '{1'b0, 1'b1, 12'h008, 32'h0000_FFC0, 1'b0, 12'h01C, 32'h02, 8'd6},  // R6 out-of-range clear bits
    '{1'b0, 1'b0, 12'h000, 32'h0000_0000, 1'b0, 12'h008, 32'h00, 8'd5},  // R5 set/clear reads 0
    '{1'b0, 1'b1, 12'h3F0, 32'hFFFF_FFFF, 1'b0, 12'h3F0, 32'h06, 8'd2},  // R2 config read-only
    '{1'b0, 1'b1, 12'h108, 32'h0002_0002, 1'b0, 12'h00C, 32'h21, 8'd10}, // R10 unmapped write
    '{1'b0, 1'b0, 12'h000, 32'h0000_0000, 1'b1, 12'h108, 32'h00, 8'd10}, // R10 unmapped read
    '{1'b0, 1'b1, 12'h00C, 32'h0000_003F, 1'b0, 12'h00C, 32'h21, 8'd10}, // R10 status read-only
    '{1'b0, 1'b1, 12'h004, 32'h0000_0003, 1'b0, 12'h004, 32'h03, 8'd8}   // R8 enable readback
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int q, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = '0;
    bus_we[q] = 1'b1;
    bus_addr[q*AW +: AW] = a;
    bus_wdata[q*32 +: 32] = d;
    @(posedge clk);
    #1;
    bus_we = '0;
  endtask

  task automatic wr2(input logic [11:0] a0, input logic [31:0] d0,
                     input logic [11:0] a1, input logic [31:0] d1);
    @(negedge clk);
    bus_we = 2'b11;
    bus_addr = {a1, a0};
    bus_wdata = {d1, d0};
    @(posedge clk);
    #1;
    bus_we = '0;
  endtask

  task automatic rd(input int q, input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_we = '0;
    bus_addr[q*AW +: AW] = a;
    @(posedge clk);
    #1;
    v = bus_rdata[q*32 +: 32];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail + 1, nchk + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "irq_rx in reset", 32'(irq_rx), 32'h0);
    check("R1", "irq_txfree in reset", 32'(irq_txfree), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    rd(0, 12'h00C, v); check("R1", "win0 status after reset", v, 32'h0);
    rd(1, 12'h01C, v); check("R1", "win1 status after reset", v, 32'h0);
    rd(1, 12'h014, v); check("R1", "win1 enables after reset", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wen) wr(int'(VEC[i].wq), VEC[i].wa, VEC[i].wd);
      rd(int'(VEC[i].rq), VEC[i].ra, v);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d", i), v, VEC[i].ex);
    end

    // state: win0 = 0x21, win1 = 0x02, win0 enables = 3, win1 enables = 0
    check("R8", "rx0 with peer ringing", 32'(irq_rx[0]), 32'h1);
    check("R9", "txfree0 with free channels", 32'(irq_txfree[0]), 32'h1);
    check("R8", "rx1 disabled", 32'(irq_rx[1]), 32'h0);
    check("R9", "txfree1 disabled", 32'(irq_txfree[1]), 32'h0);

    wr(0, 12'h008, 32'h003F_0000);
    check("R9", "txfree0 with window full", 32'(irq_txfree[0]), 32'h0);
    wr(0, 12'h008, 32'h0000_0002);
    check("R8", "rx0 after peer flags emptied", 32'(irq_rx[0]), 32'h0);
    wr(1, 12'h014, 32'h0000_0001);
    check("R8", "rx1 enabled, win0 full", 32'(irq_rx[1]), 32'h1);
    check("R9", "txfree1 still disabled", 32'(irq_txfree[1]), 32'h0);

    // R7: collision on win1 ch3
    wr2(12'h008, 32'h0000_0008, 12'h018, 32'h0008_0000);
    rd(0, 12'h01C, v); check("R7", "set beats clear", v, 32'h08);
    wr(0, 12'h008, 32'h0000_0008);
    rd(0, 12'h01C, v); check("R4", "clear alone empties", v, 32'h00);

    // R11: both ports write win1 enables
    wr2(12'h014, 32'h0000_0000, 12'h014, 32'h0000_0002);
    rd(0, 12'h014, v); check("R11", "port 1 enable write wins", v, 32'h02);
    check("R9", "txfree1 enabled, win1 empty", 32'(irq_txfree[1]), 32'h1);

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1", "irq_rx during reset", 32'(irq_rx), 32'h0);
    check("R1", "irq_txfree during reset", 32'(irq_txfree), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    rd(0, 12'h00C, v); check("R1", "win0 status after rerun reset", v, 32'h0);
    rd(0, 12'h004, v); check("R1", "win0 enables after rerun reset", v, 32'h0);
    rd(1, 12'h014, v); check("R1", "win1 enables after rerun reset", v, 32'h0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule